// File: doc/BRIEF.md
# Broadcast Command Decoder and Scan Responder

This block sits behind the slave side of a backplane interface on a digitizer module. It watches the broadcast codes addressed to every module in the crate. From them it decides two things: whether this module takes part in the data cycles that follow, and whether it must pull the shared wired-OR scan line (T) on the next read cycle. The scan answers let a crate controller find out which modules hold buffered events, or which hold data above threshold, without addressing each module in turn.

A broadcast code arrives with a one-clock strobe. The scan condition is not evaluated when the code arrives. It is evaluated when the following data cycle arrives, using the buffer and sparsifier flags present at that moment. The block also returns a slave status code for each data cycle it is selected for. That code reports an error when the secondary address held by the slave logic is invalid. The T line and the status code are one-clock pulses, registered one clock after the data-cycle strobe.

Top module: `bcast_scan_resp`

## Requirements
- R1: After reset, `selected` is 0, `t_assert` is 0 and `slave_status` is 0.
- R2: Code 8'h01 sets `selected` to 1 one clock after the broadcast strobe.
- R3: A code whose bits [3:0] are 4'h5 sets `selected` to `class_mask[bc_code[7:4]]`.
- R4: After code 8'h09 or 8'hBD, the next read data cycle raises `t_assert` only if `evt_present` is 1 during that cycle.
- R5: After code 8'h0D, the next read data cycle raises `t_assert` regardless of the status flags.
- R6: After code 8'hCD, the next read data cycle raises `t_assert` only if `evt_above` is 1 during that cycle. `evt_present` plays no part.
- R7: A scan code arms exactly one data cycle. `t_assert` is high for only the one clock after that cycle's strobe. A write cycle consumes the armed scan without raising T. Later cycles never raise T.
- R8: Any code that is not one of 8'h01, x5h, 8'h09, 8'hBD, 8'h0D or 8'hCD clears `selected` and cancels a pending scan. Scan codes also clear `selected`.
- R9: On a data cycle while `selected` is 1, `slave_status` is 3'd7 for one clock if `sa_invalid` is 1, and 3'd0 otherwise. While not selected it stays 3'd0.
- R10: Data cycles do not change `selected`. Without a pending scan they never raise `t_assert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bc_valid | input | 1 | One-clock strobe: a broadcast code is present |
| bc_code | input | 8 | Broadcast code |
| cyc_valid | input | 1 | One-clock strobe: a data cycle is present |
| cyc_read | input | 1 | Data cycle direction, 1 = read |
| sa_invalid | input | 1 | Secondary address currently loaded is invalid |
| class_mask | input | 16 | Programmed class bits, bit X enables class X |
| evt_present | input | 1 | Event buffer holds at least one event |
| evt_above | input | 1 | Current event has at least one word above threshold |
| selected | output | 1 | Module takes part in following data cycles |
| t_assert | output | 1 | Drive the wired-OR T line |
| slave_status | output | 3 | Slave status for the last data cycle (0 valid, 7 error) |

## Verification
The bench targets the one-shot nature of a scan. A design that keeps the scan armed would pull T on a second read, or on the read after an intervening write. It also checks that BDh and CDh key on different flags. A design that swaps them answers a data scan when only an event is buffered. Class selection is tried on both set and clear bits at the low and high class numbers, which catches an off-by-one nibble index. The bench also checks that unknown codes, scan codes and an x7h code drop both selection and any armed scan, and that the error status appears only while selected.

// File: rtl/bcast_scan_resp.sv
module bcast_scan_resp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bc_valid,
  input  logic [7:0]  bc_code,
  input  logic        cyc_valid,
  input  logic        cyc_read,
  input  logic        sa_invalid,
  input  logic [15:0] class_mask,
  input  logic        evt_present,
  input  logic        evt_above,
  output logic        selected,
  output logic        t_assert,
  output logic [2:0]  slave_status
);

  localparam logic [7:0] CODE_SELECT   = 8'h01;
  localparam logic [3:0] CODE_CLASS_LO = 4'h5;
  localparam logic [7:0] CODE_EVT_SCAN = 8'h09;
  localparam logic [7:0] CODE_EVT_ALT  = 8'hBD;
  localparam logic [7:0] CODE_ALL_SCAN = 8'h0D;
  localparam logic [7:0] CODE_DAT_SCAN = 8'hCD;
  localparam logic [2:0] SS_OK         = 3'd0;
  localparam logic [2:0] SS_ERR        = 3'd7;

  typedef enum logic [1:0] {SCAN_NONE, SCAN_EVT, SCAN_ALL, SCAN_DATA} scan_t;

  scan_t scan, scan_nxt;
  logic  sel_nxt;
  logic  scan_hit;

  always_comb begin
    sel_nxt  = 1'b0;
    scan_nxt = SCAN_NONE;
    if (bc_code == CODE_SELECT)
      sel_nxt = 1'b1;
    else if (bc_code[3:0] == CODE_CLASS_LO)
      sel_nxt = class_mask[bc_code[7:4]];
    else if (bc_code == CODE_EVT_SCAN || bc_code == CODE_EVT_ALT)
      scan_nxt = SCAN_EVT;
    else if (bc_code == CODE_ALL_SCAN)
      scan_nxt = SCAN_ALL;
    else if (bc_code == CODE_DAT_SCAN)
      scan_nxt = SCAN_DATA;
  end

  always_comb begin
    case (scan)
      SCAN_EVT:  scan_hit = evt_present;
      SCAN_ALL:  scan_hit = 1'b1;
      SCAN_DATA: scan_hit = evt_above;
      default:   scan_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selected     <= 1'b0;
      t_assert     <= 1'b0;
      slave_status <= SS_OK;
      scan         <= SCAN_NONE;
    end else begin
      t_assert     <= 1'b0;
      slave_status <= SS_OK;
      if (cyc_valid) begin
        t_assert <= cyc_read && scan_hit;
        scan     <= SCAN_NONE;
        if (selected)
          slave_status <= sa_invalid ? SS_ERR : SS_OK;
      end
      if (bc_valid) begin
        selected <= sel_nxt;
        scan     <= scan_nxt;
      end
    end
  end

  assert_general_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_code == 8'h01) |=> selected);

  assert_t_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    t_assert |=> !t_assert);

  assert_t_needs_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    t_assert |-> $past(cyc_valid && cyc_read));

  assert_unknown_deselects_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_code != 8'h01 && bc_code[3:0] != 4'h5) |=> !selected);

  assert_error_when_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_status != 3'd0) |-> ($past(selected && cyc_valid && sa_invalid) && slave_status == 3'd7));

  assert_cycle_keeps_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !bc_valid) |=> $stable(selected));

endmodule

// File: tb/bcast_scan_resp_test.sv
module bcast_scan_resp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bc_valid = 1'b0;
  logic [7:0]  bc_code = 8'h00;
  logic        cyc_valid = 1'b0;
  logic        cyc_read = 1'b0;
  logic        sa_invalid = 1'b0;
  logic [15:0] class_mask = 16'h0000;
  logic        evt_present = 1'b0;
  logic        evt_above = 1'b0;
  logic        selected;
  logic        t_assert;
  logic [2:0]  slave_status;

  int checks = 0;
  int errors = 0;
  logic       t_s;
  logic [2:0] ss_s;

  always #10 clk = ~clk;

  bcast_scan_resp uut (
    .clk(clk), .rst_n(rst_n), .bc_valid(bc_valid), .bc_code(bc_code),
    .cyc_valid(cyc_valid), .cyc_read(cyc_read), .sa_invalid(sa_invalid),
    .class_mask(class_mask), .evt_present(evt_present), .evt_above(evt_above),
    .selected(selected), .t_assert(t_assert), .slave_status(slave_status)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bcast(input logic [7:0] code);
    @(negedge clk);
    bc_valid = 1'b1;
    bc_code  = code;
    @(negedge clk);
    bc_valid = 1'b0;
  endtask

  // drives one data cycle, returns T and status as seen one clock later
  task automatic cycle(input logic rd, input logic bad, output logic t, output logic [2:0] ss);
    @(negedge clk);
    cyc_valid  = 1'b1;
    cyc_read   = rd;
    sa_invalid = bad;
    @(negedge clk);
    cyc_valid  = 1'b0;
    t  = t_assert;
    ss = slave_status;
    @(negedge clk);
    check("R7 release", t_assert, 0);
  endtask

  task automatic test_reset;
    check("R1 selected", selected, 0);
    check("R1 t_assert", t_assert, 0);
    check("R1 status", slave_status, 0);
  endtask

  task automatic test_general;
    bcast(8'h01);
    check("R2 select", selected, 1);
    cycle(1'b1, 1'b0, t_s, ss_s);
    check("R10 no scan no T", t_s, 0);
    check("R10 select kept", selected, 1);
  endtask

  task automatic test_class;
    class_mask = 16'h8021;
    bcast(8'h05); check("R3 class0 set", selected, 1);
    bcast(8'h15); check("R3 class1 clear", selected, 0);
    bcast(8'h55); check("R3 class5 set", selected, 1);
    bcast(8'h45); check("R3 class4 clear", selected, 0);
    bcast(8'hF5); check("R3 class15 set", selected, 1);
    class_mask = 16'h7FFF;
    bcast(8'hF5); check("R3 class15 clear", selected, 0);
  endtask

  task automatic test_status;
    bcast(8'h01);
    cycle(1'b1, 1'b1, t_s, ss_s);
    check("R9 error status", ss_s, 7);
    check("R9 status pulse", slave_status, 0);
    cycle(1'b0, 1'b0, t_s, ss_s);
    check("R9 ok status", ss_s, 0);
    bcast(8'h02);
    check("R8 unknown deselects", selected, 0);
    cycle(1'b1, 1'b1, t_s, ss_s);
    check("R9 unselected status", ss_s, 0);
  endtask

  task automatic test_evt_scan;
    bcast(8'h01);
    evt_present = 1'b0; evt_above = 1'b1;
    bcast(8'h09);
    check("R8 scan deselects", selected, 0);
    cycle(1'b1, 1'b0, t_s, ss_s); check("R4 09 empty", t_s, 0);
    evt_present = 1'b1; evt_above = 1'b0;
    bcast(8'h09);
    cycle(1'b1, 1'b0, t_s, ss_s); check("R4 09 event", t_s, 1);
    bcast(8'hBD);
    cycle(1'b1, 1'b0, t_s, ss_s); check("R4 BD event", t_s, 1);
    evt_present = 1'b0; evt_above = 1'b1;
    bcast(8'hBD);
    cycle(1'b1, 1'b0, t_s, ss_s); check("R4 BD empty", t_s, 0);
  endtask

  task automatic test_all_scan;
    evt_present = 1'b0; evt_above = 1'b0;
    bcast(8'h0D);
    cycle(1'b1, 1'b0, t_s, ss_s); check("R5 all scan", t_s, 1);
  endtask

  task automatic test_data_scan;
    evt_present = 1'b1; evt_above = 1'b0;
    bcast(8'hCD);
    cycle(1'b1, 1'b0, t_s, ss_s); check("R6 below threshold", t_s, 0);
    evt_present = 1'b0; evt_above = 1'b1;
    bcast(8'hCD);
    cycle(1'b1, 1'b0, t_s, ss_s); check("R6 above threshold", t_s, 1);
  endtask

  task automatic test_one_shot;
    bcast(8'h0D);
    cycle(1'b1, 1'b0, t_s, ss_s); check("R7 first read", t_s, 1);
    cycle(1'b1, 1'b0, t_s, ss_s); check("R7 second read", t_s, 0);
    bcast(8'h0D);
    cycle(1'b0, 1'b0, t_s, ss_s); check("R7 write no T", t_s, 0);
    cycle(1'b1, 1'b0, t_s, ss_s); check("R7 read after write", t_s, 0);
  endtask

  task automatic test_unknown;
    bcast(8'h0D);
    bcast(8'h77);
    check("R8 x7 deselects", selected, 0);
    cycle(1'b1, 1'b0, t_s, ss_s); check("R8 scan cancelled", t_s, 0);
    bcast(8'h01);
    bcast(8'hFF);
    check("R8 FF deselects", selected, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset;
    rst_n = 1'b1;
    test_general;
    test_class;
    test_status;
    test_evt_scan;
    test_all_scan;
    test_data_scan;
    test_one_shot;
    test_unknown;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule